// File: doc/BRIEF.md
# Lock-step Wide-Bundle Slot Dispatcher

This block takes one long instruction bundle per cycle and breaks it into five fixed operation slots, each wired to its own class of execution unit: slot 0 feeds the integer unit (which also resolves branches), slots 1 and 2 feed the two floating-point units, and slots 3 and 4 feed the two memory units. The split is purely positional. No decoding happens between slots, and nothing checks one operation against another. Scheduling is assumed correct when the bundle arrives.

Every unit moves in lock-step with the others. If any unit raises its busy line, the dispatcher stops accepting bundles and freezes all five slot outputs together. A slot whose opcode is zero counts as empty: its bits are still present in the bundle, but it issues nothing. A taken branch in slot 0 is reported with its target, and the dispatcher then discards the next bundle it accepts, because that bundle was fetched down the wrong path.

Top module: `bundle_dispatch`

## Requirements
- R1: The bundle is `5*SLOT_W` bits wide. Slot k occupies bits `[k*SLOT_W +: SLOT_W]`, with k=0 the integer/branch slot, k=1..2 the floating-point slots and k=3..4 the memory slots. Inside a slot, the upper `OPC_W` bits are the opcode and the lower `SLOT_W-OPC_W` bits are the operand. An accepted bundle appears on the slot outputs at the clock edge that accepts it.
- R2: A slot with an all-zero opcode is empty. Its valid output is low after acceptance, and this has no effect on the other slots.
- R3: `in_ready_o` is high exactly when no bit of `busy_i` is set. A bundle is accepted at an edge where both `in_valid_i` and `in_ready_o` are high.
- R4: While any busy bit is set, all slot valids, opcodes, operands, the taken flag and the target keep their values, whatever `in_valid_i` does.
- R5: At an edge where `in_ready_o` is high and `in_valid_i` is low, all slot valids and the taken flag go low.
- R6: When slot 0 of an accepted bundle has a nonzero opcode whose top bit is set, `br_taken_o` goes high together with the slot outputs, and `br_target_o` equals that slot's operand.
- R7: The first bundle accepted after a taken branch is discarded. All its valids and its taken flag are low, even if it holds a branch. The bundle after that issues normally. Stalls and idle cycles in between do not cancel the pending discard.
- R8: A synchronous active-high reset clears all slot valids, the taken flag and any pending discard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | A bundle is offered |
| in_bundle_i | input | 5*SLOT_W | Bundle, slot k at bits k*SLOT_W |
| in_ready_o | output | 1 | Dispatcher can accept this cycle |
| busy_i | input | 5 | Busy line per unit, bit k for slot k |
| slot_vld_o | output | 5 | Per-slot issue valid |
| slot_opc_o | output | 5*OPC_W | Per-slot opcode, slot k at k*OPC_W |
| slot_opd_o | output | 5*(SLOT_W-OPC_W) | Per-slot operand |
| br_taken_o | output | 1 | Slot 0 holds a taken branch |
| br_target_o | output | SLOT_W-OPC_W | Branch target |

## Verification
The main sweep runs through all 32 patterns of empty and filled slots. Each pattern uses opcodes and operands derived from the pattern number, so a slot that is misplaced, swapped or wrongly marked empty shows up as a mismatch in one specific position. Busy is then raised on each unit in turn while new bundles are offered, which separates a true global freeze from a stall that affects only one slot. Branch bundles are followed by stalls, idle cycles and a second branch to confirm that exactly one accepted bundle is discarded. Reset is applied while a discard is pending.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int NSLOT    = 5;
  localparam int SLOT_INT = 0;
  localparam int SLOT_FP0 = 1;
  localparam int SLOT_FP1 = 2;
  localparam int SLOT_MM0 = 3;
  localparam int SLOT_MM1 = 4;
endpackage

// File: rtl/slot_stage.sv
module slot_stage #(
  parameter int SLOT_W = 16,
  parameter int OPC_W  = 6,
  localparam int OPD_W = SLOT_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic [SLOT_W-1:0] field,
  output logic              vld,
  output logic [OPC_W-1:0]  opc,
  output logic [OPD_W-1:0]  opd
);
  function automatic logic is_live(input logic [OPC_W-1:0] code);
    return code != '0;
  endfunction

  logic [OPC_W-1:0] fld_opc;
  logic [OPD_W-1:0] fld_opd;
  assign fld_opc = field[SLOT_W-1 -: OPC_W];
  assign fld_opd = field[OPD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      opc <= '0;
      opd <= '0;
    end else if (load) begin
      vld <= is_live(fld_opc);
      opc <= fld_opc;
      opd <= fld_opd;
    end else if (clear) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/branch_ctl.sv
module branch_ctl #(
  parameter int SLOT_W = 16,
  parameter int OPC_W  = 6,
  localparam int OPD_W = SLOT_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic              drop,
  input  logic [SLOT_W-1:0] field,
  output logic              taken,
  output logic [OPD_W-1:0]  target,
  output logic              flush_pend
);
  function automatic logic is_taken(input logic [OPC_W-1:0] code);
    return code[OPC_W-1];
  endfunction

  logic now_taken;
  assign now_taken = is_taken(field[SLOT_W-1 -: OPC_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      taken      <= 1'b0;
      target     <= '0;
      flush_pend <= 1'b0;
    end else if (load) begin
      taken      <= now_taken;
      target     <= field[OPD_W-1:0];
      flush_pend <= now_taken;
    end else if (drop) begin
      taken      <= 1'b0;
      flush_pend <= 1'b0;
    end else if (clear) begin
      taken      <= 1'b0;
    end
  end
endmodule

// File: rtl/bundle_dispatch.sv
module bundle_dispatch
  import dispatch_pkg::*;
#(
  parameter int SLOT_W = 16,
  parameter int OPC_W  = 6,
  localparam int OPD_W    = SLOT_W - OPC_W,
  localparam int BUNDLE_W = NSLOT * SLOT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid_i,
  input  logic [BUNDLE_W-1:0]    in_bundle_i,
  output logic                   in_ready_o,
  input  logic [NSLOT-1:0]       busy_i,
  output logic [NSLOT-1:0]       slot_vld_o,
  output logic [NSLOT*OPC_W-1:0] slot_opc_o,
  output logic [NSLOT*OPD_W-1:0] slot_opd_o,
  output logic                   br_taken_o,
  output logic [OPD_W-1:0]       br_target_o
);
  logic accept, flush_pend, drop, load_ok, clear_ok;

  assign in_ready_o = ~|busy_i;
  assign accept     = in_valid_i & in_ready_o;
  assign drop       = accept & flush_pend;
  assign load_ok    = accept & ~flush_pend;
  assign clear_ok   = in_ready_o & (~in_valid_i | flush_pend);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    slot_stage #(.SLOT_W(SLOT_W), .OPC_W(OPC_W)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .load  (load_ok),
      .clear (clear_ok),
      .field (in_bundle_i[k*SLOT_W +: SLOT_W]),
      .vld   (slot_vld_o[k]),
      .opc   (slot_opc_o[k*OPC_W +: OPC_W]),
      .opd   (slot_opd_o[k*OPD_W +: OPD_W])
    );
  end

  branch_ctl #(.SLOT_W(SLOT_W), .OPC_W(OPC_W)) u_branch (
    .clk        (clk),
    .rst        (rst),
    .load       (load_ok),
    .clear      (clear_ok),
    .drop       (drop),
    .field      (in_bundle_i[SLOT_INT*SLOT_W +: SLOT_W]),
    .taken      (br_taken_o),
    .target     (br_target_o),
    .flush_pend (flush_pend)
  );
endmodule

// File: rtl/dispatch_checker.sv
module dispatch_checker #(
  parameter int NS   = 5,
  parameter int OPCW = 6,
  parameter int OPDW = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid_i,
  input logic [NS-1:0]      busy_i,
  input logic               accept,
  input logic               flush_pend,
  input logic [NS-1:0]      slot_vld_o,
  input logic [NS*OPCW-1:0] slot_opc_o,
  input logic [NS*OPDW-1:0] slot_opd_o,
  input logic               br_taken_o,
  input logic [OPDW-1:0]    br_target_o
);
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (|busy_i) |=> ($stable(slot_vld_o) && $stable(slot_opc_o) && $stable(slot_opd_o)
                   && $stable(br_taken_o) && $stable(br_target_o)));

  assert_idle_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (!in_valid_i && !(|busy_i)) |=> (slot_vld_o == '0 && !br_taken_o));

  assert_flush_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && flush_pend) |=> (slot_vld_o == '0 && !br_taken_o && !flush_pend));

  assert_taken_sets_pend_R6: assert property (@(posedge clk) disable iff (rst)
    br_taken_o |-> (flush_pend && slot_vld_o[0]));

  for (genvar k = 0; k < NS; k++) begin : g_nop
    assert_nop_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      slot_vld_o[k] |-> (slot_opc_o[k*OPCW +: OPCW] != '0));
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (slot_vld_o == '0 && !br_taken_o && !flush_pend));
endmodule

bind bundle_dispatch dispatch_checker #(
  .NS(dispatch_pkg::NSLOT), .OPCW(OPC_W), .OPDW(OPD_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .busy_i(busy_i),
  .accept(accept), .flush_pend(flush_pend), .slot_vld_o(slot_vld_o),
  .slot_opc_o(slot_opc_o), .slot_opd_o(slot_opd_o),
  .br_taken_o(br_taken_o), .br_target_o(br_target_o)
);

// File: tb/test_bundle_dispatch.sv
`timescale 1ns/1ps
module test_bundle_dispatch;
  localparam int SW = 16, OW = 6, DW = 10, NS = 5;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [NS*SW-1:0] bundle = '0;
  logic [NS-1:0] busy = '0;
  logic in_ready, br_taken;
  logic [NS-1:0] vld;
  logic [NS*OW-1:0] opc;
  logic [NS*DW-1:0] opd;
  logic [DW-1:0] target;

  always #10 clk = ~clk;

  bundle_dispatch #(.SLOT_W(SW), .OPC_W(OW)) i_bundle_dispatch (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_bundle_i(bundle),
    .in_ready_o(in_ready), .busy_i(busy), .slot_vld_o(vld), .slot_opc_o(opc),
    .slot_opd_o(opd), .br_taken_o(br_taken), .br_target_o(target)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [NS-1:0] e_vld;
  logic [OW-1:0] e_opc [NS];
  logic [DW-1:0] e_opd [NS];
  logic e_tk, pend;
  logic [DW-1:0] e_tgt;

  function automatic logic [NS*SW-1:0] mk(input logic [OW-1:0] c0, c1, c2, c3, c4,
                                          input int seed);
    logic [OW-1:0] cs [NS];
    logic [NS*SW-1:0] b;
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3; cs[4] = c4;
    for (int k = 0; k < NS; k++)
      b[k*SW +: SW] = {cs[k], DW'((seed * 37 + k * 101) % 1024)};
    return b;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, 64'(vld), 64'(e_vld));
    chk(req, 64'(br_taken), 64'(e_tk));
    if (e_tk) chk(req, 64'(target), 64'(e_tgt));
    for (int k = 0; k < NS; k++)
      if (e_vld[k]) begin
        chk(req, 64'(opc[k*OW +: OW]), 64'(e_opc[k]));
        chk(req, 64'(opd[k*DW +: DW]), 64'(e_opd[k]));
      end
  endtask

  // drive at negedge, update model per requirements, check at next negedge
  task automatic cyc(input logic v, input logic [NS*SW-1:0] b, input logic [NS-1:0] bz,
                     input string req);
    logic [OW-1:0] c;
    in_valid = v; bundle = b; busy = bz;
    #1 chk({req, " R3 ready"}, 64'(in_ready), 64'(bz == 0));
    if (bz == 0) begin
      if (!v) begin e_vld = '0; e_tk = 0; end
      else if (pend) begin e_vld = '0; e_tk = 0; pend = 0; end
      else begin
        for (int k = 0; k < NS; k++) begin
          c = b[k*SW+DW +: OW];
          e_opc[k] = c; e_opd[k] = b[k*SW +: DW];
          e_vld[k] = (c != 0);
        end
        e_tk = b[SW-1]; e_tgt = b[DW-1:0]; pend = e_tk;
      end
    end
    @(negedge clk);
    chk_all(req);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    e_vld = '0; e_tk = 0; pend = 0; e_tgt = '0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk_all("R8 reset state");

    // R1/R2: every empty/filled slot pattern
    for (int m = 0; m < 32; m++) begin
      logic [OW-1:0] cc [NS];
      cc[0] = m[0] ? OW'((m % 31) + 1) : '0;   // top bit 0: not a branch
      for (int k = 1; k < NS; k++) cc[k] = m[k] ? OW'(((k * 7 + m) % 63) + 1) : '0;
      cyc(1, mk(cc[0], cc[1], cc[2], cc[3], cc[4], m), '0, "R1 R2 sweep");
    end

    // R5 idle
    cyc(0, mk(6'h3, 6'h4, 6'h5, 6'h6, 6'h7, 3), '0, "R5 idle");
    cyc(1, mk(6'h3, 6'h4, 6'h5, 6'h6, 6'h7, 4), '0, "R1 refill");

    // R4 stall on each unit in turn, new bundle offered
    for (int k = 0; k < NS; k++)
      cyc(1, mk(6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 50 + k), NS'(1 << k), "R4 stall");
    cyc(0, '0, 5'h1F, "R4 stall idle");
    cyc(1, mk(6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 60), '0, "R4 release");

    // R6/R7 taken branch, then stall and idle, then a dropped branch bundle
    cyc(1, mk(6'h21, 6'h2, 6'h0, 6'h3, 6'h0, 70), '0, "R6 taken");
    cyc(1, mk(6'h1, 6'h2, 6'h3, 6'h4, 6'h5, 71), 5'h04, "R7 stall keeps pend");
    cyc(0, '0, '0, "R7 idle keeps pend");
    cyc(1, mk(6'h22, 6'h2, 6'h3, 6'h4, 6'h5, 72), '0, "R7 dropped");
    cyc(1, mk(6'h1, 6'h2, 6'h3, 6'h4, 6'h5, 73), '0, "R7 resumes");
    cyc(1, mk(6'h0, 6'h9, 6'h0, 6'h0, 6'h0, 74), '0, "R6 not-taken int");

    // R8 reset while discard pending
    cyc(1, mk(6'h3F, 6'h1, 6'h1, 6'h1, 6'h1, 80), '0, "R6 taken before reset");
    rst = 1; in_valid = 0; @(negedge clk);
    e_vld = '0; e_tk = 0; pend = 0;
    chk_all("R8 reset clears");
    rst = 0;
    cyc(1, mk(6'h1, 6'h2, 6'h3, 6'h4, 6'h5, 81), '0, "R8 no stale discard");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule